// File: doc/BRIEF.md
# SAR converter serial output port

This block is the digital serial port of a 16-bit sampling converter. The analog conversion lies outside it. The converter hands over a straight-binary result on a parallel bus together with a one-cycle done pulse. The host drives three lines into the port: a convert strobe, a serial clock and a serial data input. The port drives serial data and a separate output-enable that stands for the tri-state control of the pad. All three host lines are sampled on the block clock, and their edges are detected there.

Each time the convert strobe rises, the port reads the serial input to pick how it behaves for the next frame. With the input high it works in select mode. The output stays off while both the strobe and the serial input are high. The output turns on when either of them drops, and it turns off again when the frame has been clocked out or when the strobe rises. With the input low it works in chain mode. The output is driven for as long as the strobe stays high. Every falling edge of the serial clock shifts the register, and the serial input enters at the bottom of the register. Several ports can therefore share one data line, and each upstream result follows the local one. A parameter can place a start bit ahead of the data bits. The start bit reads 0 while a conversion is pending and 1 once the new result has been taken, so the host can use it as a busy flag.

Top module: `sar_serial_port`

## Requirements
- R1: On the clock after a convert rising edge the port is in chain mode if the serial input was low at that edge, and in select mode if it was high.
- R2: In select mode the output enable is low on every clock that follows a clock on which the convert strobe and the serial input were both high.
- R3: In select mode the output enable goes high one clock after the AND of convert and serial input falls from 1 to 0 (either line falling), and the output then shows the frame's first bit.
- R4: Each falling edge of the serial clock during an enabled frame shifts the register. The data bits go out MSB first and are the result in straight binary.
- R5: In select mode the output enable goes low one clock after the FRAME-th falling edge of the frame, or one clock after a convert rising edge, whichever comes first. FRAME is DATA_W plus the start bit.
- R6: In chain mode the output enable stays high while convert stays high and goes low one clock after convert is seen low. The serial input level at each falling edge appears on the output FRAME falling edges later, so two chained ports give 2*FRAME bits in order, local result first.
- R7: The shift register takes the parallel result on the clock after the done pulse, unless a serial-clock falling edge has already occurred in the current frame. In that case the done pulse is ignored and the frame in progress goes on with the previous result.
- R8: With START_BIT=1 the frame is DATA_W+1 bits with the start bit first. The start bit reads 0 from a convert rising edge until a result is loaded, and 1 after the load.
- R9: After reset the output enable is low and the port is in select mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all host lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe from the host; its rising edge starts a conversion and latches the mode |
| sck_i | input | 1 | Serial clock from the host; data moves on its falling edge |
| sdi_i | input | 1 | Serial input: mode select, read select, or upstream chain data |
| res_i | input | DATA_W | Parallel result from the converter |
| done_i | input | 1 | One-cycle pulse: the result on res_i is valid |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable of the serial data pad (0 = high impedance) |

## Verification
The bench reads in both select styles: one where the strobe falls, and one where the serial input falls while the strobe is high. It then checks that the enable drops after exactly FRAME edges and also when the strobe rises in the middle of a frame. A port that counted one edge too many, or missed the abort, would drive the line past the end of the frame. The bench starts a read during a conversion, lets the done pulse arrive after a few bits, and expects the whole old word. A port that loaded regardless would send a spliced word. Two ports are chained for a 32-bit read and checked bit by bit, which exposes any error in the delay. The start-bit variant is checked while a conversion is pending and again after the load.

// File: rtl/sar_sp_pkg.sv
package sar_sp_pkg;
   typedef enum logic {
      SP_MODE_SEL   = 1'b0,
      SP_MODE_CHAIN = 1'b1
   } sp_mode_e;

   function automatic int sp_frame_len(input int data_w, input int start_bit);
      return data_w + start_bit;
   endfunction
endpackage

// File: rtl/sar_sp_edges.sv
module sar_sp_edges #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] in_i,
   output logic [N-1:0] prev_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_o[g] <= 1'b0;
         else        prev_o[g] <= in_i[g];
      end
      assign rise_o[g] =  in_i[g] & ~prev_o[g];
      assign fall_o[g] = ~in_i[g] &  prev_o[g];
   end
endmodule

// File: rtl/sar_sp_bitcnt.sv
module sar_sp_bitcnt #(
   parameter int FRAME = 16,
   parameter int CW    = $clog2(FRAME + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o,
   output logic          any_o
);
   localparam logic [CW-1:0] FULL = CW'(FRAME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_o <= '0;
      else if (clr_i)                cnt_o <= '0;
      else if (inc_i && cnt_o != FULL) cnt_o <= cnt_o + 1'b1;
   end

   assign last_o = (cnt_o == FULL - 1'b1);
   assign any_o  = (cnt_o != '0);
endmodule

// File: rtl/sar_sp_shreg.sv
module sar_sp_shreg #(
   parameter int DATA_W    = 16,
   parameter int START_BIT = 0,
   parameter int FRAME     = DATA_W + START_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              shift_i,
   input  logic              ser_i,
   input  logic              mark_i,
   output logic              msb_o
);
   logic [FRAME-1:0] sr_q;
   logic [FRAME-1:0] word;
   logic [FRAME-1:0] marked;

   if (START_BIT != 0) begin : g_start
      assign word   = {1'b1, res_i};
      assign marked = {1'b0, sr_q[FRAME-2:0]};
   end else begin : g_plain
      assign word   = res_i;
      assign marked = sr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (load_i)  sr_q <= word;
      else if (shift_i) sr_q <= {sr_q[FRAME-2:0], ser_i};
      else if (mark_i)  sr_q <= marked;
   end

   assign msb_o = sr_q[FRAME-1];
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_sp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int START_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              done_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int FRAME = sp_frame_len(DATA_W, START_BIT);
   localparam int CW    = $clog2(FRAME + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("sar_serial_port: DATA_W must be at least 2");
   end
   if (START_BIT != 0 && START_BIT != 1) begin : g_bad_start
      $error("sar_serial_port: START_BIT must be 0 or 1");
   end

   logic [2:0] pins, prev, rise, fall;
   logic       cnv_rise, sck_fall, sel_hi, sel_hi_q, en_fall;
   logic       chain, rd_q, shift, busy, load;
   logic       cnt_last, cnt_any;
   logic [CW-1:0] cnt;
   sp_mode_e   mode_q;

   assign pins = {sdi_i, sck_i, cnv_i};

   sar_sp_edges #(.N(3)) u_edges (
      .clk(clk), .rst_n(rst_n), .in_i(pins),
      .prev_o(prev), .rise_o(rise), .fall_o(fall)
   );

   assign cnv_rise = rise[0];
   assign sck_fall = fall[1];
   assign sel_hi   = cnv_i & sdi_i;
   assign sel_hi_q = prev[0] & prev[2];
   assign en_fall  = sel_hi_q & ~sel_hi;
   assign chain    = (mode_q == SP_MODE_CHAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SP_MODE_SEL;
         rd_q   <= 1'b0;
      end else if (cnv_rise) begin
         mode_q <= sdi_i ? SP_MODE_SEL : SP_MODE_CHAIN;
         rd_q   <= ~sdi_i;
      end else if (chain) begin
         if (!cnv_i) rd_q <= 1'b0;
      end else begin
         if (sel_hi)                        rd_q <= 1'b0;
         else if (en_fall)                  rd_q <= 1'b1;
         else if (sck_fall && rd_q && cnt_last) rd_q <= 1'b0;
      end
   end

   assign shift = sck_fall & rd_q;
   assign busy  = rd_q & cnt_any;
   assign load  = done_i & ~busy & ~shift;

   sar_sp_bitcnt #(.FRAME(FRAME), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr_i(cnv_rise | (en_fall & ~chain)),
      .inc_i(shift),
      .cnt_o(cnt), .last_o(cnt_last), .any_o(cnt_any)
   );

   sar_sp_shreg #(.DATA_W(DATA_W), .START_BIT(START_BIT), .FRAME(FRAME)) u_sr (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .res_i(res_i),
      .shift_i(shift), .ser_i(chain & sdi_i),
      .mark_i(cnv_rise),
      .msb_o(sdo_o)
   );

   assign sdo_oe_o = rd_q;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
   parameter int FRAME = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cnv,
   input logic          sdi,
   input logic          cnv_rise,
   input logic          sck_fall,
   input logic          done,
   input logic          chain,
   input logic [CW-1:0] cnt,
   input logic          sdo,
   input logic          sdo_oe
);
   // R1
   mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnv_rise) |-> (chain == !$past(sdi)));

   // R2
   sel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnv && sdi) && !chain) |-> !sdo_oe);

   // R5
   cnv_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnv_rise) && $past(sdi)) |-> !sdo_oe);

   // R6
   chain_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnv_rise) && !$past(sdi)) |-> sdo_oe);

   // R6
   chain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain && !$past(cnv) && !$past(cnv_rise)) |-> !sdo_oe);

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(FRAME));

   // R7
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!done && !sck_fall && !cnv_rise) |-> $stable(sdo));
endmodule

bind sar_serial_port sar_serial_port_chk #(.FRAME(FRAME), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnv(cnv_i), .sdi(sdi_i),
   .cnv_rise(cnv_rise), .sck_fall(sck_fall), .done(done_i),
   .chain(chain), .cnt(cnt), .sdo(sdo_o), .sdo_oe(sdo_oe_o)
);

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;
   localparam int CLK_P = 10;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnv = 1'b0, sck = 1'b1, sdi_h = 1'b1, link = 1'b0;
   logic done_b = 1'b0, done_up = 1'b0;
   logic [DW-1:0] res_b = '0, res_up = '0;
   logic sdo_b, oe_b, sdo_up, oe_up, sdo_c, oe_c;
   logic sdi_b, sdi_up;
   int   n_chk = 0, n_fail = 0;
   bit   finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign sdi_up = link ? 1'b0 : sdi_h;
   assign sdi_b  = link ? (oe_up ? sdo_up : 1'b0) : sdi_h;

   sar_serial_port #(.DATA_W(DW)) u_up (
      .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi_up),
      .res_i(res_up), .done_i(done_up), .sdo_o(sdo_up), .sdo_oe_o(oe_up));

   sar_serial_port #(.DATA_W(DW)) u_sar_serial_port (
      .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi_b),
      .res_i(res_b), .done_i(done_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b));

   sar_serial_port #(.DATA_W(DW), .START_BIT(1)) u_sb (
      .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi_h),
      .res_i(res_b), .done_i(done_b), .sdo_o(sdo_c), .sdo_oe_o(oe_c));

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic sck_pulse();
      sck = 1'b0; cyc(2);
      sck = 1'b1; cyc(2);
   endtask

   task automatic convert(input logic [DW-1:0] vb, input logic [DW-1:0] vu);
      cnv = 1'b1; cyc(2);
      res_b = vb; res_up = vu; done_b = 1'b1; done_up = 1'b1; cyc(1);
      done_b = 1'b0; done_up = 1'b0; cyc(2);
   endtask

   task automatic t_reset();
      check("R9 oe after reset", oe_b, 0);
      check("R9 start-bit port oe after reset", oe_c, 0);
   endtask

   task automatic t_sel_3wire();
      logic [DW-1:0] v = 16'hA5C3;
      sdi_h = 1'b1; cyc(1);
      convert(v, 16'h0);
      check("R2 hiz while cnv and sdi high", oe_b, 0);
      cnv = 1'b0; cyc(1);
      check("R3 enable after cnv falls", oe_b, 1);
      for (int i = DW-1; i >= 0; i--) begin
         check($sformatf("R4 3-wire bit %0d", i), sdo_b, v[i]);
         if (i == 0) check("R5 still enabled before last edge", oe_b, 1);
         sck_pulse();
      end
      check("R5 hiz after 16th edge", oe_b, 0);
      sck_pulse();
      check("R5 stays hiz after extra edge", oe_b, 0);
   endtask

   task automatic t_sel_4wire();
      logic [DW-1:0] v = 16'h1234;
      sdi_h = 1'b1; cyc(1);
      convert(v, 16'h0);
      cyc(3);
      check("R2 hiz held with both high", oe_b, 0);
      sdi_h = 1'b0; cyc(1);
      check("R3 enable after sdi falls", oe_b, 1);
      for (int i = DW-1; i >= DW-4; i--) begin
         check($sformatf("R4 4-wire bit %0d", i), sdo_b, v[i]);
         sck_pulse();
      end
      sdi_h = 1'b1; cyc(1);
      check("R2 hiz after sdi returns high", oe_b, 0);
      cnv = 1'b0; cyc(1);
      check("R3 enable on cnv low", oe_b, 1);
      sck_pulse();
      cnv = 1'b1; cyc(1);
      check("R5 hiz after cnv rises mid-frame", oe_b, 0);
   endtask

   task automatic t_busy_read();
      logic [DW-1:0] old_v = 16'h0F0F;
      sdi_h = 1'b1; cnv = 1'b0; cyc(2);
      convert(old_v, 16'h0);
      cnv = 1'b0; cyc(2);
      cnv = 1'b1; cyc(2);
      cnv = 1'b0; cyc(1);
      for (int i = DW-1; i >= 0; i--) begin
         if (i == DW-5) begin
            res_b = 16'hBEEF; done_b = 1'b1; cyc(1); done_b = 1'b0; cyc(1);
         end
         check($sformatf("R7 old word bit %0d", i), sdo_b, old_v[i]);
         sck_pulse();
      end
      check("R5 hiz after busy frame", oe_b, 0);
   endtask

   task automatic t_chain();
      logic [2*DW-1:0] exp;
      sdi_h = 1'b0; cnv = 1'b0; cyc(2);
      cnv = 1'b1; cyc(1);
      link = 1'b1;
      res_b = 16'hC0DE; res_up = 16'h3C5A;
      done_b = 1'b1; done_up = 1'b1; cyc(1);
      done_b = 1'b0; done_up = 1'b0; cyc(2);
      exp = {16'hC0DE, 16'h3C5A};
      check("R6 chain drives while cnv high", oe_b, 1);
      for (int i = 2*DW-1; i >= 0; i--) begin
         check($sformatf("R6 chain bit %0d", i), sdo_b, exp[i]);
         sck_pulse();
      end
      check("R6 still driven after 32 edges", oe_b, 1);
      cnv = 1'b0; cyc(1);
      check("R6 hiz once cnv low", oe_b, 0);
      link = 1'b0; sdi_h = 1'b1; cyc(2);
   endtask

   task automatic t_start_bit();
      logic [DW-1:0] v = 16'h8001;
      sdi_h = 1'b1; cnv = 1'b0; cyc(2);
      cnv = 1'b1; cyc(2);
      sdi_h = 1'b0; cyc(1);
      check("R8 start-bit port enabled", oe_c, 1);
      check("R8 start bit 0 while converting", sdo_c, 0);
      res_b = v; done_b = 1'b1; cyc(1); done_b = 1'b0; cyc(1);
      check("R8 start bit 1 after load", sdo_c, 1);
      sck_pulse();
      for (int i = DW-1; i >= 0; i--) begin
         check($sformatf("R8 data bit %0d after start", i), sdo_c, v[i]);
         if (i == 0) check("R8 still enabled at edge 16", oe_c, 1);
         sck_pulse();
      end
      check("R8 hiz after 17th edge", oe_c, 0);
      sdi_h = 1'b1; cnv = 1'b0; cyc(2);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_sel_3wire();
      t_sel_4wire();
      t_busy_read();
      t_chain();
      t_start_bit();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule